// File: doc/BRIEF.md
# PLL Lock and Reference Monitor

This block watches a phase-locked loop from the outside and reports two status flags. The first, `ref_lost`, says that the horizontal-sync reference has gone quiet. It is a timeout that counts a programmable number of nominal line periods and then a programmable number of extra clock cycles, all in the 27 MHz system clock domain. The second, `lock_lost`, says that the loop is not tracking the reference. The block judges this from the up and down correction pulses that the phase detector sends to the loop filter. A locked loop with a clean reference sends few of them. A loop that is slewing toward the right frequency sends many.

The correction pulses are counted over a measurement window. The window length is a number of sync periods and is bounded by detected sync edges. When a window closes, the block compares the count with a 5-bit threshold. A reference loss overrides the lock judgement at once. The lock flag can only clear after a full window has been measured on a live reference. A window of one period with a threshold of 31 gives the quickest and least sensitive lock indication.

Top module: `pll_lock_monitor`

## Requirements
- R1: While reset is applied and after it is released, both `ref_lost` and `lock_lost` read 1. They stay at 1 until the conditions for clearing each flag are met.
- R2: Let P be `cfg_line_clks` (at least 1), L be `cfg_ref_lines` and X be `cfg_ref_extra`. Count the first rising clock edge that samples a rising `sync_in` as edge 1. If no further rising edge reaches `sync_in`, `ref_lost` is 0 after edge L·P+X+3 and becomes 1 at edge L·P+X+4.
- R3: A rising edge on `sync_in` restarts the reference timeout and clears `ref_lost` three clock edges after it is first sampled. With P=40, L=6 and X=10, five consecutive missing sync pulses do not assert `ref_lost`.
- R4: `lock_lost` is 1 in every cycle in which `ref_lost` is 1.
- R5: The measurement window opens at a detected sync edge and closes at the `cfg_win_lines`-th detected sync edge after that. At the close, `lock_lost` is set to 1 if the correction events counted in the window exceed `cfg_thresh`, and is cleared to 0 otherwise. Events detected in the closing edge's own cycle belong to the closing window. The new value is visible from the clock after the closing edge is detected.
- R6: An event count equal to `cfg_thresh` keeps the loop judged locked. A count of `cfg_thresh`+1 judges it unlocked.
- R7: Each rising edge of `corr_up` and each rising edge of `corr_dn` is one event. Rising edges on both in the same cycle count as two.
- R8: The event count saturates at 31, so with `cfg_thresh`=31 no window is judged unlocked, even with more than 31 events in it.
- R9: While `ref_lost` is 1, the window and its count are held cleared. The sync edge that restores the reference opens a new window. `lock_lost` stays 1 until that window closes within the threshold.
- R10: Between window closes, `lock_lost` does not change, whatever correction activity occurs, unless `ref_lost` rises.
- R11: A `cfg_win_lines` value of 0 is treated as a window of one sync period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_in | input | 1 | Horizontal-sync reference, asynchronous |
| corr_up | input | 1 | Phase-detector up correction pulse, asynchronous |
| corr_dn | input | 1 | Phase-detector down correction pulse, asynchronous |
| cfg_line_clks | input | LINE_W | Nominal sync period in clock cycles |
| cfg_ref_lines | input | 3 | Reference timeout, whole sync periods |
| cfg_ref_extra | input | EXTRA_W | Reference timeout, extra clock cycles |
| cfg_win_lines | input | WIN_W | Measurement window length in sync periods |
| cfg_thresh | input | 5 | Largest event count still judged locked |
| ref_lost | output | 1 | Loss-of-reference flag |
| lock_lost | output | 1 | Loss-of-lock flag |

## Verification
A corrupted timeout counter shows up as a `ref_lost` edge that is early or late. The bench pins that edge to one exact clock, so an off-by-one in either the line or the extra-cycle stage is caught. A miscount in the event counter or the window position changes the lock verdict. That verdict is only visible one window later, in the line after the closing sync edge, so the bench samples each verdict there. Threshold-equal and threshold-plus-one counts, simultaneous up/down edges and saturation are each placed so that a single-event error flips the result.

// File: rtl/lkm_pkg.sv
package lkm_pkg;
    localparam int CNT_W     = 5;
    localparam int REFL_W    = 3;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // saturating add of up to two events to the window count
    function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                                 input logic [1:0] b);
        logic [CNT_W:0] sum;
        sum = {1'b0, a} + {{(CNT_W-1){1'b0}}, b};
        return sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/lkm_edge_sync.sv
module lkm_edge_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] rise_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rise
        assign rise_o[i] = st_q.sync[i] & ~st_q.prev[i];
    end

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[0] |=> !rise_o[0]); // R7
endmodule

// File: rtl/lkm_ref_watch.sv
module lkm_ref_watch #(
    parameter int LINE_W  = 12,
    parameter int EXTRA_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       edge_i,
    input  logic [LINE_W-1:0]          cfg_line_clks,
    input  logic [lkm_pkg::REFL_W-1:0] cfg_ref_lines,
    input  logic [EXTRA_W-1:0]         cfg_ref_extra,
    output logic                       ref_lost_o
);
    import lkm_pkg::*;

    typedef struct packed {
        logic [LINE_W-1:0]  line_cnt;
        logic [REFL_W-1:0]  lines;
        logic [EXTRA_W-1:0] ext_cnt;
        logic               lost;
    } st_t;

    st_t st_d, st_q;
    logic line_end;
    logic in_lines;

    assign line_end = (st_q.line_cnt == cfg_line_clks - LINE_W'(1)) || (cfg_line_clks == '0);
    assign in_lines = (st_q.lines != cfg_ref_lines);

    always_comb begin
        st_d = st_q;
        if (edge_i) begin
            st_d.line_cnt = '0;
            st_d.lines    = '0;
            st_d.ext_cnt  = '0;
            st_d.lost     = 1'b0;
        end else if (!st_q.lost) begin
            if (in_lines) begin
                if (line_end) begin
                    st_d.line_cnt = '0;
                    st_d.lines    = st_q.lines + REFL_W'(1);
                end else begin
                    st_d.line_cnt = st_q.line_cnt + LINE_W'(1);
                end
            end else if (st_q.ext_cnt == cfg_ref_extra) begin
                st_d.lost = 1'b1;
            end else begin
                st_d.ext_cnt = st_q.ext_cnt + EXTRA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_lost_o = st_q.lost;

    AST_EDGE_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !ref_lost_o); // R3
    AST_REF_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost_o) |-> !$past(edge_i)); // R2
endmodule

// File: rtl/lkm_lock_judge.sv
module lkm_lock_judge #(
    parameter int WIN_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      edge_i,
    input  logic                      up_i,
    input  logic                      dn_i,
    input  logic                      ref_lost_i,
    input  logic [WIN_W-1:0]          cfg_win_lines,
    input  logic [lkm_pkg::CNT_W-1:0] cfg_thresh,
    output logic                      lock_bad_o
);
    import lkm_pkg::*;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] cnt;
        logic             bad;
    } st_t;

    st_t st_d, st_q;
    logic [WIN_W-1:0] win_last;
    logic [CNT_W-1:0] total;
    logic             boundary;

    assign win_last = (cfg_win_lines == '0) ? '0 : cfg_win_lines - WIN_W'(1);
    assign total    = sat_add(st_q.cnt, {1'b0, up_i} + {1'b0, dn_i});
    assign boundary = !ref_lost_i && edge_i && (st_q.win == win_last);

    always_comb begin
        st_d = st_q;
        if (ref_lost_i) begin
            st_d.win = '0;
            st_d.cnt = '0;
            st_d.bad = 1'b1;
        end else if (boundary) begin
            st_d.win = '0;
            st_d.cnt = '0;
            st_d.bad = (total > cfg_thresh);
        end else begin
            st_d.cnt = total;
            if (edge_i) st_d.win = st_q.win + WIN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.bad <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_bad_o = st_q.bad;

    AST_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !ref_lost_i) |=> $stable(lock_bad_o)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_MAX && !boundary && !ref_lost_i) |=> (st_q.cnt == CNT_MAX)); // R8
    AST_REF_FORCES_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lost_i |=> lock_bad_o); // R9
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
    parameter int LINE_W  = 12,
    parameter int EXTRA_W = 12,
    parameter int WIN_W   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_in,
    input  logic                        corr_up,
    input  logic                        corr_dn,
    input  logic [LINE_W-1:0]           cfg_line_clks,
    input  logic [lkm_pkg::REFL_W-1:0]  cfg_ref_lines,
    input  logic [EXTRA_W-1:0]          cfg_ref_extra,
    input  logic [WIN_W-1:0]            cfg_win_lines,
    input  logic [lkm_pkg::CNT_W-1:0]   cfg_thresh,
    output logic                        ref_lost,
    output logic                        lock_lost
);
    localparam int N_IN = 3;

    logic [N_IN-1:0] rise;
    logic            ref_lost_w;
    logic            lock_bad_w;

    lkm_edge_sync #(.WIDTH(N_IN)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({corr_dn, corr_up, sync_in}),
        .rise_o (rise)
    );

    lkm_ref_watch #(.LINE_W(LINE_W), .EXTRA_W(EXTRA_W)) u_ref (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_i        (rise[0]),
        .cfg_line_clks (cfg_line_clks),
        .cfg_ref_lines (cfg_ref_lines),
        .cfg_ref_extra (cfg_ref_extra),
        .ref_lost_o    (ref_lost_w)
    );

    lkm_lock_judge #(.WIN_W(WIN_W)) u_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .edge_i        (rise[0]),
        .up_i          (rise[1]),
        .dn_i          (rise[2]),
        .ref_lost_i    (ref_lost_w),
        .cfg_win_lines (cfg_win_lines),
        .cfg_thresh    (cfg_thresh),
        .lock_bad_o    (lock_bad_w)
    );

    assign ref_lost  = ref_lost_w;
    assign lock_lost = lock_bad_w | ref_lost_w;

    AST_LOCK_FALLS_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> $past(rise[0])); // R5
    AST_REF_IMPLIES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_lost) |=> lock_lost); // R4
endmodule

// File: tb/pll_lock_monitor_tb_top.sv
module pll_lock_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_in = 1'b0, corr_up = 1'b0, corr_dn = 1'b0;
    logic [11:0] cfg_line_clks = 12'd40;
    logic [2:0]  cfg_ref_lines = 3'd6;
    logic [11:0] cfg_ref_extra = 12'd10;
    logic [4:0]  cfg_win_lines = 5'd2;
    logic [4:0]  cfg_thresh = 5'd3;
    logic        ref_lost, lock_lost;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp_ref;
        logic  exp_lock;
        string tag;
    } exp_t;
    exp_t sb_q[$];
    event sample_ev;

    always #5 clk = ~clk;

    pll_lock_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .corr_up(corr_up), .corr_dn(corr_dn),
        .cfg_line_clks(cfg_line_clks), .cfg_ref_lines(cfg_ref_lines),
        .cfg_ref_extra(cfg_ref_extra), .cfg_win_lines(cfg_win_lines),
        .cfg_thresh(cfg_thresh), .ref_lost(ref_lost), .lock_lost(lock_lost)
    );

    task automatic note(input bit ok, input string tag, input string what,
                        input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // monitor: compares outputs against the oldest expected item
    initial begin
        forever begin
            @(sample_ev);
            if (sb_q.size() == 0) begin
                note(1'b0, "SB", "empty queue", 1'b0, 1'b1);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                note(ref_lost === it.exp_ref, it.tag, "ref_lost", ref_lost, it.exp_ref);
                note(lock_lost === it.exp_lock, it.tag, "lock_lost", lock_lost, it.exp_lock);
            end
        end
    end

    task automatic expect_now(input logic r, input logic l, input string tag);
        exp_t it;
        it.exp_ref = r; it.exp_lock = l; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
    endtask

    // one 40-cycle sync period; n correction pulses (n <= 7) from cycle 10
    task automatic run_line(input int n, input bit both, input bit skip, input bit chk,
                            input logic er, input logic el, input string tag);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            sync_in = !skip && (c < 2);
            corr_up = 1'b0;
            corr_dn = 1'b0;
            for (int k = 0; k < n; k++) begin
                if (c == 10 + 4 * k || c == 11 + 4 * k) begin
                    if (both || (k % 2 == 0)) corr_up = 1'b1;
                    if (both || (k % 2 == 1)) corr_dn = 1'b1;
                end
            end
            if (chk && c == 8) expect_now(er, el, tag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            note(1'b0, "WATCHDOG", "timeout", 1'b0, 1'b1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        expect_now(1'b1, 1'b1, "R1");           // in reset
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_now(1'b1, 1'b1, "R1");           // after release
        // W=2, thr=3
        run_line(3, 0, 0, 1, 0, 1, "R3");       // edge restores ref; window opens
        run_line(0, 0, 0, 1, 0, 1, "R9");       // first window still open
        run_line(4, 0, 0, 1, 0, 0, "R6");       // 3 events == thr -> locked
        run_line(0, 0, 0, 1, 0, 0, "R10");      // 4 events so far, no change mid-window
        run_line(1, 0, 0, 1, 0, 1, "R6");       // 4 > 3 -> unlocked
        run_line(1, 0, 0, 1, 0, 1, "R10");
        run_line(2, 1, 0, 1, 0, 0, "R5");       // 2 events -> locked again
        run_line(0, 0, 0, 0, 0, 0, "");
        run_line(7, 0, 0, 1, 0, 1, "R7");       // 2 double edges = 4 events -> unlocked
        cfg_win_lines = 5'd5;
        cfg_thresh    = 5'd31;
        for (int i = 0; i < 4; i++) run_line(7, 0, 0, 0, 0, 0, "");
        run_line(1, 0, 0, 1, 0, 0, "R8");       // 35 events saturate at 31 -> locked
        cfg_win_lines = 5'd0;
        cfg_thresh    = 5'd0;
        run_line(0, 0, 0, 1, 0, 1, "R11");      // one-line window with 1 event > 0
        run_line(0, 0, 0, 1, 0, 0, "R11");      // one-line window with 0 events
        cfg_win_lines = 5'd1;
        cfg_thresh    = 5'd31;
        for (int i = 0; i < 5; i++) run_line(0, 0, 1, 1, 0, 0, "R3");   // blanking gap
        run_line(0, 0, 0, 1, 0, 0, "R3");
        repeat (214) @(negedge clk);
        expect_now(1'b0, 1'b0, "R2");           // edge 253: still present
        @(negedge clk);
        expect_now(1'b1, 1'b1, "R4");           // edge 254: both flags up
        run_line(0, 0, 0, 1, 0, 1, "R9");       // ref back, lock still lost
        run_line(0, 0, 0, 1, 0, 0, "R9");       // clean window closes -> locked
        repeat (4) @(negedge clk);
        note(sb_q.size() == 0, "SB", "queue drained", 1'(sb_q.size() == 0), 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule